// File: doc/BRIEF.md
# Short-Cycle SAR Conversion Sequencer

This block is the digital core of a successive-approximation converter. It owns the approximation register, steps it through a binary search one bit per clock, and presents a trial code to an external DAC. An external comparator reports each step's outcome on a single input. A pulse on the start input clears the register, latches the cycle-length selection and enables the bit clock. The sequencer then works from the most significant bit down to the least.

The cycle length is picked at start. A low mode input gives a full 12-bit conversion. A high mode input gives a shortened 8-bit conversion whose low nibble is filled with a fixed pattern. A busy flag covers the whole conversion. Once busy is up, nothing stops the conversion or starts it again. When the conversion completes, busy drops, the bit clock stops and the result is held on its own output until the next conversion finishes.

Top module: `sar_seq`

## Requirements
- R1: An accepted start clears the approximation register to zero and raises the bit-clock enable, so the first trial code is exactly the most significant bit alone (12'h800), whatever the previous result was.
- R2: Trials run from bit 11 down to bit 0. On step k (k = 0 first) the trial code holds the bits already decided above position 11-k, has bit 11-k set, and has all bits below it clear. Each comparator result is registered before it affects the trial code.
- R3: A comparator input of 1 (analog input above the DAC level) keeps the bit under trial; a 0 clears it. With a comparator that returns 1 exactly when the trial code is at or below an input code, a 12-bit conversion yields that input code.
- R4: The mode input is sampled only when a start is accepted: 0 selects a 12-bit cycle and 1 selects an 8-bit cycle. Changes to it during a conversion have no effect.
- R5: An 8-bit conversion produces result bits [11:4] from the search, bit 3 set to 1, and bits [2:0] equal to 0.
- R6: Busy rises on the clock edge that accepts a start. It stays high for 13 cycles in a 12-bit conversion and 9 cycles in an 8-bit conversion, which is one cycle per bit plus one finishing cycle.
- R7: A start request while busy is high neither restarts nor resets the conversion. Its result and length are unchanged.
- R8: At the end of a conversion the bit-clock enable falls together with busy. The result output takes the new value and then holds it while idle, whatever the comparator does.
- R9: Reset clears busy, the bit-clock enable, the latched mode, the trial code and the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only while idle |
| short_i | input | 1 | Cycle-length select, sampled at start: 1 = 8-bit, 0 = 12-bit |
| cmp_hi_i | input | 1 | Comparator result: 1 when the analog input is above the DAC output |
| trial_o | output | 12 | Trial code to the external DAC |
| busy_o | output | 1 | High while a conversion is in progress |
| bitclk_en_o | output | 1 | Bit-clock enable, high during conversion |
| result_o | output | 12 | Result of the last completed conversion |

## Verification
The bench models an ideal comparator from the trial code and a target input code. It sweeps every 12-bit input code in full mode, where the result must equal the code. It sweeps every code again in short mode, where the result shows the truncated upper byte with the fixed fill. On selected codes the per-step trial codes are compared against the expected binary-search path. This shows whether the bit order and the one-cycle comparator registration are correct, not merely whether the final value is right.

Some conversions receive a start pulse and a flipped mode bit partway through. This separates a sequencer that ignores restarts from one that re-latches its mode. A run with all ones followed by one with all zeros shows that a start really clears the register. Idle periods with a toggling comparator show that the result holds.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    LEN_FULL  = 1'b0,
    LEN_SHORT = 1'b1
  } conv_len_e;

  // bit position tried on a given step (may go negative past the last step)
  function automatic int trial_pos(input int width, input int step);
    return width - 1 - step;
  endfunction

  // bit position whose comparator outcome is resolved on a given step
  function automatic int pend_pos(input int width, input int step);
    return width - step;
  endfunction
endpackage

// File: rtl/sar_cmp_reg.sv
module sar_cmp_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_hi_i,
  output logic cmp_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmp_q_o <= 1'b0;
    else         cmp_q_o <= cmp_hi_i;
  end
endmodule

// File: rtl/sar_step_ctrl.sv
module sar_step_ctrl
  import sar_pkg::*;
#(
  parameter int W       = 12,
  parameter int SHORT_W = 8,
  parameter int STEP_W  = $clog2(W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              short_i,
  output logic              busy_o,
  output logic              accept_o,
  output logic              fin_o,
  output logic              short_o,
  output logic [STEP_W-1:0] step_o
);
  localparam logic [STEP_W-1:0] LAST_FULL  = STEP_W'(W);
  localparam logic [STEP_W-1:0] LAST_SHORT = STEP_W'(SHORT_W);

  logic              busy_q;
  conv_len_e         mode_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] last_step;

  assign last_step = (mode_q == LEN_SHORT) ? LAST_SHORT : LAST_FULL;
  assign accept_o  = start_i && !busy_q;
  assign fin_o     = busy_q && (step_q == last_step);
  assign busy_o    = busy_q;
  assign short_o   = (mode_q == LEN_SHORT);
  assign step_o    = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      mode_q <= LEN_FULL;
      step_q <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      mode_q <= conv_len_e'(short_i);
      step_q <= '0;
    end else if (fin_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      step_q <= step_q + 1'b1;
    end
  end

  // R7
  restart_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !fin_o && start_i) |=> (busy_q && step_q == STEP_W'($past(step_q) + 1'b1)));

  // R4
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(mode_q));

  // R6
  fin_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !busy_q);

  // R6
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (step_q <= last_step));
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
  import sar_pkg::*;
#(
  parameter int W       = 12,
  parameter int SHORT_W = 8,
  parameter int STEP_W  = $clog2(W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              busy_i,
  input  logic              fin_i,
  input  logic              short_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              cmp_q_i,
  output logic [W-1:0]      trial_o,
  output logic [W-1:0]      result_o
);
  localparam int FILL_POS = W - SHORT_W - 1;

  function automatic logic [W-1:0] bit_at(input int pos);
    logic [W-1:0] m;
    m = '0;
    if (pos >= 0 && pos < W) m[pos] = 1'b1;
    return m;
  endfunction

  function automatic logic [W-1:0] resolve(input logic [W-1:0] acc,
                                           input int step, input logic keep);
    if (step == 0 || keep) return acc;
    return acc & ~bit_at(pend_pos(W, step));
  endfunction

  logic [W-1:0] acc_q;
  logic [W-1:0] result_q;
  logic [W-1:0] resolved;
  logic [W-1:0] final_val;
  logic [W-1:0] fill_mask;

  assign fill_mask = short_i ? bit_at(FILL_POS) : '0;
  assign resolved  = resolve(acc_q, int'(step_i), cmp_q_i);
  assign final_val = resolved | fill_mask;

  always_comb begin
    if (busy_i && !fin_i) trial_o = resolved | bit_at(trial_pos(W, int'(step_i)));
    else if (busy_i)      trial_o = resolved;
    else                  trial_o = acc_q;
  end

  assign result_o = result_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      result_q <= '0;
    end else if (accept_i) begin
      acc_q <= '0;
    end else if (fin_i) begin
      acc_q    <= final_val;
      result_q <= final_val;
    end else if (busy_i) begin
      acc_q <= trial_o;
    end
  end

  // R1
  clear_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> (acc_q == '0));

  // R2
  trial_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !fin_i) |-> ((trial_o & bit_at(trial_pos(W, int'(step_i)))) != '0));

  // R5
  short_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_i && short_i) |=> (result_o[FILL_POS:0] == bit_at(FILL_POS)[FILL_POS:0]));

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin_i |=> $stable(result_q));
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int W       = 12,
  parameter int SHORT_W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         short_i,
  input  logic         cmp_hi_i,
  output logic [W-1:0] trial_o,
  output logic         busy_o,
  output logic         bitclk_en_o,
  output logic [W-1:0] result_o
);
  localparam int STEP_W = $clog2(W + 1);

  logic              accept;
  logic              fin;
  logic              busy;
  logic              short_latched;
  logic              cmp_q;
  logic [STEP_W-1:0] step;

  sar_cmp_reg u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmp_hi_i (cmp_hi_i),
    .cmp_q_o  (cmp_q)
  );

  sar_step_ctrl #(.W(W), .SHORT_W(SHORT_W), .STEP_W(STEP_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .short_i  (short_i),
    .busy_o   (busy),
    .accept_o (accept),
    .fin_o    (fin),
    .short_o  (short_latched),
    .step_o   (step)
  );

  sar_trial_reg #(.W(W), .SHORT_W(SHORT_W), .STEP_W(STEP_W)) u_trial (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .busy_i   (busy),
    .fin_i    (fin),
    .short_i  (short_latched),
    .step_i   (step),
    .cmp_q_i  (cmp_q),
    .trial_o  (trial_o),
    .result_o (result_o)
  );

  assign busy_o      = busy;
  assign bitclk_en_o = busy;
endmodule

// File: tb/sar_seq_bench.sv
module sar_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_r = 1'b0;
  logic        short_r = 1'b0;
  logic        cmp_hi;
  logic [11:0] vin = 12'h000;
  logic [11:0] trial_o;
  logic        busy_o;
  logic        bitclk_en_o;
  logic [11:0] result_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // ideal comparator: analog input at or above the trial level keeps the bit
  always_comb cmp_hi = (trial_o <= vin);

  sar_seq u_sar_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start_r),
    .short_i     (short_r),
    .cmp_hi_i    (cmp_hi),
    .trial_o     (trial_o),
    .busy_o      (busy_o),
    .bitclk_en_o (bitclk_en_o),
    .result_o    (result_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_trial(input logic [11:0] v, input int k);
    logic [11:0] upper;
    upper = v & ~12'((1 << (12 - k)) - 1);
    return upper | 12'(1 << (11 - k));
  endfunction

  function automatic logic [11:0] exp_result(input logic [11:0] v, input bit sh);
    if (sh) return (v & 12'hFF0) | 12'h008;
    return v;
  endfunction

  task automatic convert(input logic [11:0] v, input bit sh, input bit poke, input bit trials);
    int n;
    int cyc;
    n = sh ? 8 : 12;
    @(negedge clk);
    vin = v; short_r = sh; start_r = 1'b1;
    @(negedge clk);
    start_r = 1'b0;
    cyc = 0;
    while (busy_o && cyc < 40) begin
      if (cyc == 0) chk(bitclk_en_o == 1'b1, "R1", int'(bitclk_en_o), 1);
      if (trials && cyc == 0) chk(trial_o == 12'h800, "R1", int'(trial_o), 12'h800);
      if (trials && cyc < n) chk(trial_o == exp_trial(v, cyc), "R2", int'(trial_o), int'(exp_trial(v, cyc)));
      if (poke && cyc == 3) begin start_r = 1'b1; short_r = !sh; end
      else if (poke && cyc == 4) begin start_r = 1'b0; short_r = sh; end
      cyc++;
      @(negedge clk);
    end
    start_r = 1'b0; short_r = sh;
    chk(cyc == n + 1, sh ? "R6" : "R6", cyc, n + 1);
    if (sh) chk(result_o == exp_result(v, 1'b1), "R5", int'(result_o), int'(exp_result(v, 1'b1)));
    else    chk(result_o == exp_result(v, 1'b0), "R3", int'(result_o), int'(exp_result(v, 1'b0)));
    if (poke) chk(result_o == exp_result(v, sh), "R7", int'(result_o), int'(exp_result(v, sh)));
    chk(bitclk_en_o == 1'b0, "R8", int'(bitclk_en_o), 0);
  endtask

  task automatic hold_check(input bit sh);
    logic [11:0] kept;
    kept = result_o;
    vin = ~vin;
    repeat (5) @(negedge clk);
    chk(result_o == kept, "R8", int'(result_o), int'(kept));
    chk(busy_o == 1'b0, "R8", int'(busy_o), 0);
    short_r = !sh;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(busy_o == 1'b0, "R9", int'(busy_o), 0);
    chk(bitclk_en_o == 1'b0, "R9", int'(bitclk_en_o), 0);
    chk(result_o == 12'h000, "R9", int'(result_o), 0);
    chk(trial_o == 12'h000, "R9", int'(trial_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: all ones then all zeros; second must start from a clear register
    convert(12'hFFF, 1'b0, 1'b0, 1'b1);
    hold_check(1'b0);
    convert(12'h000, 1'b0, 1'b0, 1'b1);
    hold_check(1'b0);

    // R3 / R2: full-mode sweep of every input code
    for (int v = 0; v < 4096; v++) begin
      convert(12'(v), 1'b0, (v % 64) == 5, (v % 97) == 0);
    end
    hold_check(1'b0);

    // R4 / R5: short-mode sweep of every input code
    for (int v = 0; v < 4096; v++) begin
      convert(12'(v), 1'b1, (v % 64) == 9, (v % 89) == 0);
    end
    hold_check(1'b1);

    // R4: alternate modes back to back
    convert(12'hA5C, 1'b1, 1'b1, 1'b1);
    convert(12'hA5C, 1'b0, 1'b1, 1'b1);
    convert(12'h7FF, 1'b1, 1'b0, 1'b1);
    hold_check(1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule